// File: doc/BRIEF.md
# Centre Half-Sample Luma Interpolator

This block produces an 8x8 block of luma samples at the position halfway between integer samples in both directions. A 13x13 window of 8-bit source samples enters one row per handshake beat, 13 bytes wide. Each row passes through a horizontal six-tap filter, and the unclipped signed result is kept. A vertical six-tap filter then combines six such intermediate rows column by column. One combined rounding shift by 10 and a saturation to 0..255 produce the final samples.

A `start` pulse arms the block for a new window. The first five accepted rows only fill the intermediate history. Each later accepted row yields one 8-sample output row on the next cycle. The eighth output row carries `done`. The output row waits in a register until the consumer takes it. While it waits, the input side is held off.

Top module: `hpel_center_interp`

## Requirements
- R1: After reset `in_ready`, `out_valid` and `done` are all low.
- R2: One cycle after a `start` pulse, with no output row pending, `in_ready` is high.
- R3: For a window with source samples s(y,x), y and x in -2..10, output (r,c) is clip255((V + 512) >>> 10), computed as follows.
  - The horizontal intermediate is H(y,c) = s(y,c-2) - 5s(y,c-1) + 20s(y,c) + 20s(y,c+1) - 5s(y,c+2) + s(y,c+3). It is kept as a signed 16-bit value with no rounding or clipping.
  - V applies the same taps down a column to H(r-2,c) .. H(r+3,c).
- R4: The final shift is arithmetic. Negative sums saturate to 0 and results above 255 saturate to 255. An all-zero window gives 0 and an all-255 window gives 255.
- R5: Output row r (0..7) becomes valid in the cycle after input row r+5 (0-based arrival order) is accepted. No output is valid before the sixth accepted row.
- R6: Input byte j, bits [8j+7:8j] of `in_row`, is source column j-2. Output column c occupies bits [8c+7:8c] of `out_row`. Input rows arrive from source row -2 upward.
- R7: `done` is high exactly while the eighth output row (r = 7) is valid.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_row` holds its value.
- R9: After the thirteenth row is accepted, `in_ready` stays low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms the block for a new 13-row window |
| in_valid | input | 1 | Source row present |
| in_ready | output | 1 | Source row can be accepted |
| in_row | input | 104 | 13 source samples of one row, byte j = column j-2 |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | 64 | 8 interpolated samples, byte c = column c |
| done | output | 1 | Marks the last output row of the block |

## Verification
The assertions assume three things about the inputs:
- `start` is never raised while a window is half delivered.
- `start` does not coincide with an accepted row.
- The consumer does not rely on a pending output row surviving a `start`.

The bench raises `start` only after all eight rows of the previous block have been taken, with `in_valid` low. Within a block, random gaps on `in_valid` and random stalls on `out_ready` exercise back-pressure without breaking these conditions.

// File: rtl/hpel_pkg.sv
`timescale 1ns/1ps
package hpel_pkg;
  // six-tap half-sample kernel geometry
  localparam int unsigned TAPS  = 6;
  localparam int unsigned LEAD  = 2;   // samples before the output position
  localparam int unsigned SHIFT = 10;  // combined scale of both stages

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_e;
endpackage

// File: rtl/hpel_tap6.sv
`timescale 1ns/1ps
// Symmetric (1,-5,20,20,-5,1) sum built from shifts and adds.
module hpel_tap6 #(
  parameter int unsigned W = 16
) (
  input  logic [6*W-1:0]   taps_i,
  output logic signed [W-1:0] sum_o
);
  logic signed [W-1:0] x0, x1, x2, x3, x4, x5;
  logic signed [W-1:0] outer, mid, inner;

  always_comb begin
    x0 = $signed(taps_i[0*W +: W]);
    x1 = $signed(taps_i[1*W +: W]);
    x2 = $signed(taps_i[2*W +: W]);
    x3 = $signed(taps_i[3*W +: W]);
    x4 = $signed(taps_i[4*W +: W]);
    x5 = $signed(taps_i[5*W +: W]);
    outer = x0 + x5;
    mid   = x1 + x4;
    inner = x2 + x3;
    sum_o = outer - (mid <<< 2) - mid + (inner <<< 4) + (inner <<< 2);
  end
endmodule

// File: rtl/hpel_hstage.sv
`timescale 1ns/1ps
module hpel_hstage #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned OUT_COLS = 8
) (
  input  logic [(OUT_COLS+hpel_pkg::TAPS-1)*PIX_W-1:0] pix_i,
  output logic [OUT_COLS*IMM_W-1:0]                    imm_o
);
  localparam int unsigned TAPS = hpel_pkg::TAPS;

  for (genvar c = 0; c < OUT_COLS; c++) begin : g_col
    logic [TAPS*IMM_W-1:0] win;
    logic signed [IMM_W-1:0] sum;
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign win[k*IMM_W +: IMM_W] =
        {{(IMM_W-PIX_W){1'b0}}, pix_i[(c+k)*PIX_W +: PIX_W]};
    end
    hpel_tap6 #(.W(IMM_W)) u_tap (.taps_i(win), .sum_o(sum));
    assign imm_o[c*IMM_W +: IMM_W] = sum;
  end
endmodule

// File: rtl/hpel_rowbuf.sv
`timescale 1ns/1ps
// History of intermediate rows; slot 0 holds the newest.
module hpel_rowbuf #(
  parameter int unsigned ROW_W = 128,
  parameter int unsigned DEPTH = 5
) (
  input  logic                   clk,
  input  logic                   shift_en,
  input  logic [ROW_W-1:0]       row_i,
  output logic [DEPTH*ROW_W-1:0] rows_o
);
  logic [ROW_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (shift_en) begin
      slot_q[0] <= row_i;
      for (int k = 1; k < DEPTH; k++) slot_q[k] <= slot_q[k-1];
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign rows_o[k*ROW_W +: ROW_W] = slot_q[k];
  end
endmodule

// File: rtl/hpel_vstage.sv
`timescale 1ns/1ps
module hpel_vstage #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned ACC_W    = 22,
  parameter int unsigned OUT_COLS = 8
) (
  input  logic [(hpel_pkg::TAPS-1)*OUT_COLS*IMM_W-1:0] hist_i,
  input  logic [OUT_COLS*IMM_W-1:0]                    fresh_i,
  output logic [OUT_COLS*PIX_W-1:0]                    pix_o
);
  localparam int unsigned TAPS  = hpel_pkg::TAPS;
  localparam int unsigned SHIFT = hpel_pkg::SHIFT;
  localparam int unsigned ROW_W = OUT_COLS*IMM_W;
  localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1) <<< (SHIFT-1);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  for (genvar c = 0; c < OUT_COLS; c++) begin : g_col
    logic [TAPS*ACC_W-1:0]   win;
    logic signed [ACC_W-1:0] sum, scaled;
    logic [IMM_W-1:0]        oldest_first [TAPS];

    // tap 0 = oldest row (history slot TAPS-2), tap TAPS-1 = fresh row
    for (genvar k = 0; k < TAPS-1; k++) begin : g_hist
      assign oldest_first[k] = hist_i[(TAPS-2-k)*ROW_W + c*IMM_W +: IMM_W];
    end
    assign oldest_first[TAPS-1] = fresh_i[c*IMM_W +: IMM_W];

    for (genvar k = 0; k < TAPS; k++) begin : g_ext
      assign win[k*ACC_W +: ACC_W] =
        {{(ACC_W-IMM_W){oldest_first[k][IMM_W-1]}}, oldest_first[k]};
    end

    hpel_tap6 #(.W(ACC_W)) u_tap (.taps_i(win), .sum_o(sum));

    always_comb begin
      scaled = (sum + RND) >>> SHIFT;
      if (scaled < 0)
        pix_o[c*PIX_W +: PIX_W] = '0;
      else if (scaled > PIX_MAX)
        pix_o[c*PIX_W +: PIX_W] = '1;
      else
        pix_o[c*PIX_W +: PIX_W] = scaled[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/hpel_center_interp.sv
`timescale 1ns/1ps
module hpel_center_interp #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned ACC_W    = 22,
  parameter int unsigned OUT_COLS = 8,
  parameter int unsigned OUT_ROWS = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic [(OUT_COLS+hpel_pkg::TAPS-1)*PIX_W-1:0] in_row,
  output logic                                        out_valid,
  input  logic                                        out_ready,
  output logic [OUT_COLS*PIX_W-1:0]                   out_row,
  output logic                                        done
);
  import hpel_pkg::*;

  localparam int unsigned IN_ROWS   = OUT_ROWS + TAPS - 1;
  localparam int unsigned CNT_W     = $clog2(IN_ROWS + 1);
  localparam int unsigned HIST      = TAPS - 1;
  localparam int unsigned ROW_W     = OUT_COLS * IMM_W;
  localparam logic [CNT_W-1:0] FIRST_OUT = CNT_W'(TAPS - 1);
  localparam logic [CNT_W-1:0] LAST_IN   = CNT_W'(IN_ROWS - 1);

  run_e             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ov_q, ov_d, done_q, done_d;
  logic [OUT_COLS*PIX_W-1:0] row_q;
  logic             accept, take, emit;

  logic [ROW_W-1:0]      imm_row;
  logic [HIST*ROW_W-1:0] hist;
  logic [OUT_COLS*PIX_W-1:0] vrow;

  hpel_hstage #(.PIX_W(PIX_W), .IMM_W(IMM_W), .OUT_COLS(OUT_COLS)) u_h (
    .pix_i(in_row), .imm_o(imm_row)
  );

  hpel_rowbuf #(.ROW_W(ROW_W), .DEPTH(HIST)) u_buf (
    .clk(clk), .shift_en(take), .row_i(imm_row), .rows_o(hist)
  );

  hpel_vstage #(.PIX_W(PIX_W), .IMM_W(IMM_W), .ACC_W(ACC_W),
                .OUT_COLS(OUT_COLS)) u_v (
    .hist_i(hist), .fresh_i(imm_row), .pix_o(vrow)
  );

  assign in_ready = (run_q == ST_RUN) && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign take     = accept && !start;
  assign emit     = take && (cnt_q >= FIRST_OUT);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    ov_d   = ov_q;
    done_d = done_q;
    if (start) begin
      run_d  = ST_RUN;
      cnt_d  = '0;
      ov_d   = 1'b0;
      done_d = 1'b0;
    end else begin
      if (take) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IN) run_d = ST_IDLE;
      end
      if (emit) begin
        ov_d   = 1'b1;
        done_d = (cnt_q == LAST_IN);
      end else if (out_ready) begin
        ov_d   = 1'b0;
        done_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= ST_IDLE;
      cnt_q  <= '0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      ov_q   <= ov_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) row_q <= vrow;
  end

  assign out_valid = ov_q;
  assign out_row   = row_q;
  assign done      = done_q;
endmodule

// File: rtl/hpel_center_interp_chk.sv
`timescale 1ns/1ps
module hpel_center_interp_chk #(
  parameter int unsigned OUT_COLS = 8,
  parameter int unsigned OUT_ROWS = 8,
  parameter int unsigned PIX_W    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [OUT_COLS*PIX_W-1:0]  out_row,
  input logic                       done
);
  localparam int unsigned IN_ROWS = OUT_ROWS + hpel_pkg::TAPS - 1;
  localparam int unsigned CNT_W   = $clog2(IN_ROWS + 1);
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(hpel_pkg::TAPS - 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(IN_ROWS - 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(IN_ROWS);

  logic [CNT_W-1:0] seen_q;
  logic             acc;
  assign acc = in_valid && in_ready && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_q <= '0;
    else if (start)                 seen_q <= '0;
    else if (acc && seen_q < FULL)  seen_q <= seen_q + 1'b1;
  end

  p_stall_holds_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_row));

  p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_done_with_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  p_done_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen_q == LAST |=> done);

  p_row_follows_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen_q >= FIRST |=> out_valid);

  p_no_early_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= FIRST |-> !out_valid);

  p_closed_after_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q == FULL |-> !in_ready);
endmodule

bind hpel_center_interp hpel_center_interp_chk #(
  .OUT_COLS(OUT_COLS), .OUT_ROWS(OUT_ROWS), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_row(out_row), .done(done)
);

// File: tb/hpel_center_interp_test.sv
`timescale 1ns/1ps
module hpel_center_interp_test;
  logic         clk, rst_n, start, in_valid, in_ready, out_valid, out_ready, done;
  logic [103:0] in_row;
  logic [63:0]  out_row;
  int checks, errors;
  logic [7:0] win [13][13];

  hpel_center_interp uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_row(in_row), .out_valid(out_valid),
    .out_ready(out_ready), .out_row(out_row), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wt(input int k);
    case (k)
      0, 5: return 1;
      1, 4: return -5;
      default: return 20;
    endcase
  endfunction

  // R3/R4 reference: window row y holds source row y-2, column x holds x-2
  function automatic int ref_pix(input int r, input int c);
    int v = 0;
    for (int ky = 0; ky < 6; ky++) begin
      int h = 0;
      for (int kx = 0; kx < 6; kx++) h += wt(kx) * int'(win[r+ky][c+kx]);
      v += wt(ky) * h;
    end
    v = (v + 512) >>> 10;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic logic [63:0] exp_row(input int r);
    logic [63:0] e;
    for (int c = 0; c < 8; c++) e[c*8 +: 8] = 8'(ref_pix(r, c));
    return e;
  endfunction

  function automatic logic [103:0] pack_row(input int y);
    logic [103:0] p;
    for (int j = 0; j < 13; j++) p[j*8 +: 8] = win[y][j];
    return p;
  endfunction

  task automatic fill(input int kind);
    for (int y = 0; y < 13; y++)
      for (int x = 0; x < 13; x++)
        case (kind)
          0: win[y][x] = 8'd0;
          1: win[y][x] = 8'd255;
          3: win[y][x] = (x % 3 == 1 && y % 3 == 1) ? 8'd255 : 8'd0;
          4: win[y][x] = (x == 6 && y == 6) ? 8'd255 : 8'd0;
          default: win[y][x] = 8'($urandom_range(255));
        endcase
  endtask

  task automatic run_block(input int kind, input int stall_pct, input int gap_pct,
                           input string req);
    int sent = 0, got = 0, cyc = 0, prev_acc = -1;
    bit prev_stall = 0;
    logic [63:0] prev_row = '0;
    fill(kind);
    @(negedge clk); start = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); start = 1'b0;
    #1 check(in_ready === 1'b1, "R2 ready after start", {63'd0, in_ready}, 64'd1);
    while (got < 8 && cyc < 2000) begin
      @(negedge clk); cyc++;
      out_ready = ($urandom_range(99) >= stall_pct);
      in_valid  = (sent < 13) && ($urandom_range(99) >= gap_pct);
      in_row    = (sent < 13) ? pack_row(sent) : '0;
      #1;
      if (prev_acc >= 5)
        check(out_valid && out_row === exp_row(prev_acc - 5), "R5 row after accept",
              out_row, exp_row(prev_acc - 5));
      if (prev_stall)
        check(out_valid && out_row === prev_row, "R8 row held", out_row, prev_row);
      if (prev_acc < 5 && sent < 6)
        check(!out_valid, "R5 no early row", {63'd0, out_valid}, 64'd0);
      prev_stall = out_valid && !out_ready;
      prev_row   = out_row;
      if (prev_stall)
        check(!in_ready, "R8 input held off", {63'd0, in_ready}, 64'd0);
      if (out_valid && out_ready) begin
        check(out_row === exp_row(got), req, out_row, exp_row(got));
        check(done === (got == 7), "R7 done", {63'd0, done}, {63'd0, got == 7});
        got++;
      end
      if (in_valid && in_ready) begin prev_acc = sent; sent++; end
      else prev_acc = -1;
    end
    if (cyc >= 2000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", got, 8);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; out_ready = 1'b1;
      #1 check(!in_ready && !out_valid, "R9 closed after window",
               {62'd0, in_ready, out_valid}, 64'd0);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(!in_ready && !out_valid && !done, "R1 reset state",
             {61'd0, in_ready, out_valid, done}, 64'd0);
    run_block(0, 0, 0, "R3 zero window");
    run_block(1, 0, 0, "R4 saturate high");
    run_block(3, 20, 10, "R4 saturate low");
    run_block(4, 0, 0, "R6 impulse placement");
    for (int b = 0; b < 6; b++) run_block(2, 30, 25, "R3 random window");
    run_block(2, 0, 0, "R3 random window no stall");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog global timeout actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule